// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local memory-mapped slave port and the PCI Express transaction layer. It rewrites the address of each outbound request. The local address space is split into equally sized windows. The bits just above the per-window offset pick one entry of a runtime-writable table. That entry supplies the upper part of the PCI Express address, and the offset bits are copied through untouched.

Each table entry holds a 64-bit window base and a 2-bit space code. The space code says whether the request leaves as a 32-bit or a 64-bit memory address. Requests that hit an entry carrying a reserved code are dropped and flagged. Software loads the table one entry at a time through a small write port, writing a low 32-bit word and a high 32-bit word separately.

The translation result is registered. A single output register with ready/valid handshaking gives one cycle of latency, and the block still accepts a new request on every cycle in which the downstream side is taking data.

Top module: `xlat_outbound`

## Requirements
- R1: After reset `out_valid` and `xlat_err` are 0, `req_ready` is 1, and every table entry holds base 0 with space code 00.
- R2: The entry index is `req_addr[SEG_BITS +: IDX_BITS]`, which is bits 24:16 at the default parameters.
- R3: Bits `SEG_BITS-1:0` of `out_addr` equal the same bits of the accepted `req_addr`.
- R4: Bits `63:SEG_BITS` of `out_addr` come from the selected entry's base, except where R5 clears them.
- R5: Space code 00 means 32-bit memory: `out_is64` is 0 and `out_addr[63:32]` is 0. Space code 01 means 64-bit memory: `out_is64` is 1 and the full base is used.
- R6: Space codes 10 and 11 are reserved. An accepted request that selects such an entry produces no output beat. Instead `xlat_err` is 1 for exactly the next cycle.
- R7: A write with `cfg_wr_hi`=0 stores `cfg_wr_data[31:2]` into base bits 31:2 and `cfg_wr_data[1:0]` into the space code of entry `cfg_wr_idx`. A write with `cfg_wr_hi`=1 stores `cfg_wr_data` into base bits 63:32. Base bits 1:0 are always 0.
- R8: A request accepted in the same cycle as a table write to the entry it selects is translated with the entry's contents from before that write.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` equals `!out_valid || out_ready`. The translated beat appears on the cycle after acceptance, and it stays valid and unchanged while `out_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | SEG_BITS+IDX_BITS (25) | Local byte address |
| out_valid | output | 1 | Translated beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_addr | output | 64 | Translated PCI Express address |
| out_is64 | output | 1 | 1 when the beat uses 64-bit addressing |
| xlat_err | output | 1 | One-cycle pulse for a request dropped on a reserved code |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_hi | input | 1 | 0 selects the low word, 1 selects the high word |
| cfg_wr_idx | input | IDX_BITS (9) | Entry being written |
| cfg_wr_data | input | 32 | Write data |

## Verification
Three results are due on the edge that follows an accepted request: the translated beat, its width flag and the error pulse. `req_ready` is due in the same cycle as the `out_ready` that drives it. The bench drives its inputs at the falling edge, reads `req_ready` shortly afterwards, and advances its reference model by that cycle's handshake. At the next falling edge it compares every output against the model, after exactly one register stage. The model applies a table write only after it has computed the lookup for that same cycle, which gives the R8 ordering. A beat the model is still holding must reappear unchanged for as long as `out_ready` stays low.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    SP_MEM32 = 2'b00,
    SP_MEM64 = 2'b01,
    SP_RSV2  = 2'b10,
    SP_RSV3  = 2'b11
  } space_e;

  typedef struct packed {
    logic [1:0]  sp;
    logic [63:0] base;
  } xlat_entry_t;

  typedef struct packed {
    logic        is64;
    logic [63:0] addr;
  } xlat_beat_t;

  // Only the 32-bit and 64-bit memory codes may be forwarded.
  function automatic logic space_ok(input logic [1:0] sp);
    return (sp == SP_MEM32) || (sp == SP_MEM64);
  endfunction

  // Base supplies bits above the window offset; the offset passes through.
  function automatic logic [63:0] xlat_compose(input logic [63:0] base,
                                               input logic [63:0] laddr,
                                               input int unsigned seg_bits,
                                               input logic [1:0]  sp);
    logic [63:0] mask;
    logic [63:0] res;
    mask = (64'd1 << seg_bits) - 64'd1;
    res  = (base & ~mask) | (laddr & mask);
    if (sp == SP_MEM32) res[63:32] = '0;
    return res;
  endfunction

endpackage

// File: rtl/xlat_table.sv
module xlat_table
  import xlat_pkg::*;
#(
  parameter int IDX_BITS = 9,
  localparam int ENTRIES = 1 << IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [31:0]         wr_data,
  input  logic [IDX_BITS-1:0] rd_idx,
  output xlat_entry_t         rd_entry
);

  xlat_entry_t        tbl [ENTRIES];
  logic [ENTRIES-1:0] wr_sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    assign wr_sel[g] = wr_en && (wr_idx == IDX_BITS'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_sel[i]) begin
          if (wr_hi) begin
            tbl[i].base[63:32] <= wr_data;
          end else begin
            tbl[i].base[31:2] <= wr_data[31:2];
            tbl[i].sp         <= wr_data[1:0];
          end
        end
      end
    end
  end

  // Read sees the contents before any write landing on this same edge.
  assign rd_entry = tbl[rd_idx];

  assert_wr_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (tbl[$past(wr_idx)].sp == $past(wr_data[1:0])));

  assert_wr_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (tbl[$past(wr_idx)].base[63:32] == $past(wr_data)));

endmodule

// File: rtl/xlat_stage.sv
module xlat_stage
  import xlat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  xlat_beat_t din,
  output logic       in_ready,
  output logic       vld,
  input  logic       rdy,
  output xlat_beat_t dout
);

  logic       vld_q;
  xlat_beat_t dat_q;

  assign in_ready = !vld_q || rdy;
  assign vld      = vld_q;
  assign dout     = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= din;
    end else if (rdy) begin
      vld_q <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rdy) |=> (vld_q && $stable(dat_q)));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> vld_q);

endmodule

// File: rtl/xlat_outbound.sv
module xlat_outbound
  import xlat_pkg::*;
#(
  parameter int SEG_BITS = 16,
  parameter int IDX_BITS = 9,
  localparam int LOCAL_AW = SEG_BITS + IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LOCAL_AW-1:0] req_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [63:0]         out_addr,
  output logic                out_is64,
  output logic                xlat_err,
  input  logic                cfg_wr_en,
  input  logic                cfg_wr_hi,
  input  logic [IDX_BITS-1:0] cfg_wr_idx,
  input  logic [31:0]         cfg_wr_data
);

  logic [IDX_BITS-1:0] lkp_idx;
  xlat_entry_t         lkp_entry;
  logic                req_fire;
  logic                sp_legal;
  logic                fwd_load;
  logic                err_load;
  xlat_beat_t          beat_in;
  xlat_beat_t          beat_out;
  logic                err_q;

  assign lkp_idx = req_addr[SEG_BITS +: IDX_BITS];

  xlat_table #(.IDX_BITS(IDX_BITS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_hi    (cfg_wr_hi),
    .wr_idx   (cfg_wr_idx),
    .wr_data  (cfg_wr_data),
    .rd_idx   (lkp_idx),
    .rd_entry (lkp_entry)
  );

  assign req_fire = req_valid && req_ready;
  assign sp_legal = space_ok(lkp_entry.sp);
  assign fwd_load = req_fire && sp_legal;
  assign err_load = req_fire && !sp_legal;

  assign beat_in.is64 = (lkp_entry.sp == SP_MEM64);
  assign beat_in.addr = xlat_compose(lkp_entry.base, 64'(req_addr),
                                     SEG_BITS, lkp_entry.sp);

  xlat_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fwd_load),
    .din      (beat_in),
    .in_ready (req_ready),
    .vld      (out_valid),
    .rdy      (out_ready),
    .dout     (beat_out)
  );

  assign out_addr = beat_out.addr;
  assign out_is64 = beat_out.is64;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_load;
  end
  assign xlat_err = err_q;

  assert_low_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |=> (out_valid && out_addr[SEG_BITS-1:0] == $past(req_addr[SEG_BITS-1:0])));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is64) |-> (out_addr[63:32] == 32'd0));

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_err |-> !out_valid);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_load |=> xlat_err);

endmodule

// File: tb/xlat_outbound_tb_top.sv
`timescale 1ns/1ps
module xlat_outbound_tb_top;
  localparam int SEG  = 16;
  localparam int IDX  = 9;
  localparam int LAW  = SEG + IDX;
  localparam int NENT = 1 << IDX;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           req_valid, req_ready;
  logic [LAW-1:0] req_addr;
  logic           out_valid, out_ready, out_is64, xlat_err;
  logic [63:0]    out_addr;
  logic           cfg_wr_en, cfg_wr_hi;
  logic [IDX-1:0] cfg_wr_idx;
  logic [31:0]    cfg_wr_data;

  xlat_outbound #(.SEG_BITS(SEG), .IDX_BITS(IDX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_is64(out_is64), .xlat_err(xlat_err),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_hi(cfg_wr_hi), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data)
  );

  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;
  string       cur_tag = "R1";
  logic [64:0] expq[$];
  bit          exp_err = 0;
  logic [63:0] sh_base [NENT];
  logic [1:0]  sh_sp   [NENT];

  function automatic void check(bit ok, string tag, logic [63:0] act,
                                logic [63:0] exp, string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [LAW-1:0] mk(int idx, int off);
    logic [LAW-1:0] a;
    a = {idx[IDX-1:0], off[SEG-1:0]};
    return a;
  endfunction

  task automatic observe();
    bit ev;
    ev = (expq.size() > 0);
    check(out_valid == ev, "R9", 64'(out_valid), 64'(ev), "out_valid");
    if (ev && out_valid) begin
      check(out_addr[SEG-1:0] == expq[0][SEG-1:0], "R3", out_addr, expq[0][63:0], "offset bits");
      check(out_addr[63:SEG] == expq[0][63:SEG], cur_tag, out_addr, expq[0][63:0], "upper bits");
      check(out_is64 == expq[0][64], "R5", 64'(out_is64), 64'(expq[0][64]), "out_is64");
    end
    check(xlat_err == exp_err, "R6", 64'(xlat_err), 64'(exp_err), "xlat_err");
  endtask

  task automatic step(bit v, logic [LAW-1:0] a, bit rdy, bit we, bit hi,
                      int idx, logic [31:0] d);
    bit          mr;
    int          li;
    logic [63:0] e;
    @(negedge clk);
    observe();
    req_valid = v; req_addr = a; out_ready = rdy;
    cfg_wr_en = we; cfg_wr_hi = hi; cfg_wr_idx = idx[IDX-1:0]; cfg_wr_data = d;
    #1;
    mr = (expq.size() == 0) || rdy;
    check(req_ready == mr, "R9", 64'(req_ready), 64'(mr), "req_ready");
    if (expq.size() > 0 && rdy) void'(expq.pop_front());
    exp_err = 0;
    if (v && mr) begin
      li = int'(a / (1 << SEG));
      e  = {sh_base[li][63:SEG], a[SEG-1:0]};
      if (sh_sp[li] >= 2'd2) exp_err = 1;
      else begin
        if (sh_sp[li] == 2'b00) e = e & 64'h0000_0000_FFFF_FFFF;
        expq.push_back({sh_sp[li] == 2'b01, e});
      end
    end
    if (we) begin
      if (hi) sh_base[idx][63:32] = d;
      else begin
        sh_base[idx][31:2] = d[31:2];
        sh_sp[idx] = d[1:0];
      end
    end
  endtask

  task automatic lookup(int idx, int off);
    step(1, mk(idx, off), 1, 0, 0, 0, 32'd0);
  endtask

  task automatic wr(int idx, bit hi, logic [31:0] d);
    step(0, '0, 1, 1, hi, idx, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 1, 0, 0, 0, 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin sh_base[i] = '0; sh_sp[i] = '0; end
    rst_n = 0; req_valid = 0; req_addr = '0; out_ready = 1;
    cfg_wr_en = 0; cfg_wr_hi = 0; cfg_wr_idx = '0; cfg_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1", 64'(out_valid), 0, "reset out_valid");
    check(xlat_err == 0, "R1", 64'(xlat_err), 0, "reset xlat_err");
    check(req_ready == 1, "R1", 64'(req_ready), 1, "reset req_ready");
    rst_n = 1;

    // R1: fresh table gives zero base, 32-bit
    cur_tag = "R1";
    lookup(0, 16'h1234); lookup(300, 16'hFFFF); lookup(511, 0);
    idle(2);

    // R5: 32-bit entry with nonzero high word; R4: 64-bit entry at top index
    cur_tag = "R5";
    wr(0, 1, 32'hAAAA_BBBB); wr(0, 0, 32'h1234_5600);
    lookup(0, 16'h00C3);
    cur_tag = "R4";
    wr(511, 1, 32'h0000_00F1); wr(511, 0, 32'hDEAD_0001);
    lookup(511, 16'hBEEF); lookup(511, 0);
    idle(2);

    // R2: neighbouring indices select distinct bases
    cur_tag = "R2";
    wr(5, 0, 32'h5555_0001); wr(5, 1, 32'h0000_0005);
    wr(6, 0, 32'h6666_0001); wr(6, 1, 32'h0000_0006);
    lookup(5, 16'h0010); lookup(6, 16'h0010); lookup(5, 16'hFFF0); lookup(256 + 5, 1);
    idle(2);

    // R7: low word and high word land independently
    cur_tag = "R7";
    wr(12, 0, 32'h00AB_0001); lookup(12, 7);
    wr(12, 1, 32'hCAFE_F00D); lookup(12, 7);
    wr(12, 0, 32'h0077_0000); lookup(12, 9);
    idle(2);

    // R6: reserved codes are dropped and flagged
    cur_tag = "R6";
    wr(7, 0, 32'h7000_0002); wr(8, 0, 32'h8000_0003);
    lookup(7, 1); lookup(8, 2); lookup(5, 3); lookup(7, 4); idle(1);
    idle(2);

    // R8: lookup in the write cycle sees old contents
    cur_tag = "R8";
    wr(9, 1, 32'h0000_0011); wr(9, 0, 32'h0001_0001);
    step(1, mk(9, 16'h0042), 1, 1, 0, 9, 32'h0099_0000);
    lookup(9, 16'h0042);
    step(1, mk(9, 16'h0043), 1, 1, 0, 9, 32'h0000_0002);
    lookup(9, 16'h0044);
    idle(2);

    // R9: backpressure holds the beat and blocks new requests
    cur_tag = "R9";
    step(1, mk(5, 1), 0, 0, 0, 0, 32'd0);
    step(1, mk(6, 2), 0, 0, 0, 0, 32'd0);
    step(1, mk(6, 2), 0, 0, 0, 0, 32'd0);
    step(1, mk(6, 2), 1, 0, 0, 0, 32'd0);
    step(1, mk(511, 3), 1, 0, 0, 0, 32'd0);
    idle(2);

    // Mixed traffic
    cur_tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      int          ix;
      int          wi;
      logic [31:0] wd;
      ix = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NENT - 1) : $urandom_range(0, 15);
      wi = $urandom_range(0, 15);
      wd = $urandom;
      step($urandom_range(0, 2) != 0, mk(ix, $urandom_range(0, 65535)),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, wi, wd);
    end
    idle(3);

    done = 1;
    summary();
    $finish;
  end

endmodule